// File: doc/BRIEF.md
# LIN Byte-Slot Bit Timer with Superfractional Stretch

This block times the ten bit positions of one LIN byte slot: a start bit, eight data bits sent least significant first, and a stop bit. Each bit length is a number of peripheral clock cycles. It is built from an integer prescaler P, a 4-bit fractional addend M and a 3-bit stretch selector S. The selector picks a fixed ten-entry pattern. Each pattern entry marks a slot position that receives one extra clock cycle, so over a byte the average bit time lands between two integer cycle counts.

A one-cycle start-of-byte pulse opens a slot. On that pulse the block samples P, M, S, the node role (master or slave) and a 2-bit field-type code. From these it decides whether the stretch pattern applies to the byte. It then pulses a strobe on the last clock cycle of every bit and shows the index of the position being timed. The serializer, the receive sampler, break generation and the checksum logic sit outside and follow the strobe.

The control is a two-state machine: `ST_IDLE` and `ST_TIMING`. It has four named transitions:
- **T_START** goes from `ST_IDLE` to `ST_TIMING` on a start pulse.
- **T_NEXT** stays in `ST_TIMING` when a bit other than the stop bit ends.
- **T_RESTART** stays in `ST_TIMING` when a start pulse arrives during a slot, and opens a fresh slot.
- **T_DONE** goes from `ST_TIMING` to `ST_IDLE` when the stop bit ends and no start pulse is present.

Top module: `lin_bit_timer`

## Requirements
- R1: Positions are indexed 0 = start, 1..8 = D0..D7, 9 = stop on `bit_idx_o`. The index rises by one in the cycle after each strobe. After the stop-bit strobe it holds at 9 with no further strobes until the next start pulse. While no strobe and no start pulse occur, it never changes.
- R2: With P not 0, a bit lasts 16*(P+1) + M + d clock cycles. Here d is 1 only when stretch is enabled for the byte and the pattern marks the position.
- R3: With P = 0, every bit lasts exactly 32 cycles, whatever M, S, role and field.
- R4: The positions stretched for each S are:
  - S=0: none.
  - S=1: 0 and 8.
  - S=2: 0, 4 and 8.
  - S=3: 0, 2, 4 and 8.
  - S=4: 0, 2, 4, 6 and 8.
  - S=5: 0, 1, 2, 4, 6, 8 and 9.
  - S=6: 0, 1, 2, 4, 5, 6, 8 and 9.
  - S=7: every position except 7.
- R5: Field codes on `field_i` are 0 sync, 1 identifier, 2 response and 3 checksum.
  - With `master_i`=1, stretch applies to codes 0, 1 and 2.
  - With `master_i`=0, it applies to codes 1 and 2 only.
  - Every other case gives d = 0 in all positions.
- R6: `bit_end_o` is high for exactly one cycle, the last cycle of each bit. The cycle following the clock edge that samples a start pulse is cycle 1 of position 0.
- R7: P, M, S, role and field are sampled only at a start pulse. Changing them during a slot does not alter any bit of that slot.
- R8: A start pulse during a slot abandons it. The index reads 0 in the next cycle, and the new slot is timed with the newly sampled settings.
- R9: When a start pulse falls in the same cycle as the stop-bit strobe, the strobe is still given and a new slot begins at position 0 without an idle cycle.
- R10: During and after reset, before any start pulse, `bit_end_o` is 0 and `bit_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sob_i | input | 1 | Start-of-byte pulse, one cycle |
| master_i | input | 1 | 1 = master node, 0 = slave node |
| field_i | input | 2 | Field type: 0 sync, 1 identifier, 2 response, 3 checksum |
| pre_i | input | PRE_W (8) | Integer prescaler P |
| frac_i | input | FRAC_W (4) | Fractional addend M |
| sel_i | input | SEL_W (3) | Stretch pattern selector S |
| bit_end_o | output | 1 | High on the last cycle of each bit |
| bit_idx_o | output | 4 | Slot position being timed |

## Verification
Two functions can meet in one clock cycle: the stop-bit strobe that closes a slot, and a start pulse that opens the next. The bench provokes this by watching for the stop-bit strobe and raising the start pulse in that very cycle, with different settings. It then judges that the strobe was seen and that the next bit is timed at position 0 with the new settings. A start pulse placed mid-bit, in the middle of a slot, is judged the same way against the restarted slot's expected lengths.

// File: rtl/lin_bt_pkg.sv
package lin_bt_pkg;

    localparam int SLOT_BITS = 10;

    typedef enum logic [1:0] {
        FLD_SYNC  = 2'd0,
        FLD_IDENT = 2'd1,
        FLD_RESP  = 2'd2,
        FLD_CKSUM = 2'd3
    } field_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_TIMING = 1'b1
    } state_e;

endpackage

// File: rtl/lin_bt_pattern.sv
module lin_bt_pattern #(
    parameter int SEL_W     = 3,
    parameter int SLOT_BITS = 10
) (
    input  logic [SEL_W-1:0]     sel_i,
    output logic [SLOT_BITS-1:0] mask_o
);
    // bit p of mask_o marks slot position p (0 start, 1..8 data, 9 stop)
    always_comb begin
        unique case (sel_i)
            SEL_W'(1): mask_o = SLOT_BITS'(10'h101);
            SEL_W'(2): mask_o = SLOT_BITS'(10'h111);
            SEL_W'(3): mask_o = SLOT_BITS'(10'h115);
            SEL_W'(4): mask_o = SLOT_BITS'(10'h155);
            SEL_W'(5): mask_o = SLOT_BITS'(10'h357);
            SEL_W'(6): mask_o = SLOT_BITS'(10'h377);
            SEL_W'(7): mask_o = SLOT_BITS'(10'h37F);
            default:   mask_o = '0;
        endcase
    end
endmodule

// File: rtl/lin_bt_len.sv
module lin_bt_len #(
    parameter int PRE_W     = 8,
    parameter int FRAC_W    = 4,
    parameter int OVS_SHIFT = 4,
    parameter int LEN_W     = 13,
    parameter int FIXED_LEN = 32
) (
    input  logic [PRE_W-1:0]  pre_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              extra_i,
    output logic [LEN_W-1:0]  len_o
);
    logic [LEN_W-1:0] base;

    always_comb begin
        base = (LEN_W'(pre_i) + LEN_W'(1)) << OVS_SHIFT;
        if (pre_i == '0) begin
            len_o = LEN_W'(FIXED_LEN);
        end else begin
            len_o = base + LEN_W'(frac_i) + LEN_W'(extra_i);
        end
    end
endmodule

// File: rtl/lin_bit_timer.sv
module lin_bit_timer
    import lin_bt_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int FRAC_W = 4,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sob_i,
    input  logic              master_i,
    input  logic [1:0]        field_i,
    input  logic [PRE_W-1:0]  pre_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              bit_end_o,
    output logic [3:0]        bit_idx_o
);
    localparam int OVS_SHIFT = 4;
    localparam int FIXED_LEN = 32;
    localparam int LEN_W     = PRE_W + OVS_SHIFT + 1;
    localparam int IDX_W     = 4;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOT_BITS - 1);

    state_e                 state_q, state_d;
    logic [IDX_W-1:0]       idx_q;
    logic [LEN_W-1:0]       cnt_q;
    logic [PRE_W-1:0]       pre_q;
    logic [FRAC_W-1:0]      frac_q;
    logic [SLOT_BITS-1:0]   mask_q;
    logic                   mod_q;

    logic [SLOT_BITS-1:0]   mask_new;
    logic                   mod_new;
    logic                   extra;
    logic [LEN_W-1:0]       cur_len;
    logic                   at_end;

    lin_bt_pattern #(.SEL_W(SEL_W), .SLOT_BITS(SLOT_BITS)) u_pattern (
        .sel_i  (sel_i),
        .mask_o (mask_new)
    );

    lin_bt_len #(
        .PRE_W(PRE_W), .FRAC_W(FRAC_W), .OVS_SHIFT(OVS_SHIFT),
        .LEN_W(LEN_W), .FIXED_LEN(FIXED_LEN)
    ) u_len (
        .pre_i   (pre_q),
        .frac_i  (frac_q),
        .extra_i (extra),
        .len_o   (cur_len)
    );

    // stretch enable: identifier/response always, sync only for a master
    always_comb begin
        unique case (field_e'(field_i))
            FLD_IDENT, FLD_RESP: mod_new = 1'b1;
            FLD_SYNC:            mod_new = master_i;
            default:             mod_new = 1'b0;
        endcase
    end

    assign extra  = mod_q & mask_q[idx_q];
    assign at_end = (state_q == ST_TIMING) && (cnt_q == cur_len);

    // next state: T_START, T_RESTART, T_NEXT, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sob_i) state_d = ST_TIMING;                  // T_START
            end
            ST_TIMING: begin
                if (sob_i)                            state_d = ST_TIMING; // T_RESTART
                else if (at_end && idx_q == LAST_IDX) state_d = ST_IDLE;   // T_DONE
                else                                  state_d = ST_TIMING; // T_NEXT / count
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // slot datapath: settings capture, bit counter, position index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            cnt_q  <= LEN_W'(1);
            pre_q  <= '0;
            frac_q <= '0;
            mask_q <= '0;
            mod_q  <= 1'b0;
        end else if (sob_i) begin
            idx_q  <= '0;
            cnt_q  <= LEN_W'(1);
            pre_q  <= pre_i;
            frac_q <= frac_i;
            mask_q <= mask_new;
            mod_q  <= mod_new;
        end else if (state_q == ST_TIMING) begin
            if (at_end) begin
                cnt_q <= LEN_W'(1);
                if (idx_q != LAST_IDX) idx_q <= idx_q + IDX_W'(1);
            end else begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        bit_end_o = at_end;
        bit_idx_o = idx_q;
    end
endmodule

// File: rtl/lin_bt_chk.sv
module lin_bt_chk #(
    parameter int IDX_W    = 4,
    parameter int LAST_IDX = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sob_i,
    input logic             bit_end_o,
    input logic [IDX_W-1:0] bit_idx_o
);
    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end_o |=> !bit_end_o);

    // R6
    first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sob_i |=> !bit_end_o);

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx_o <= IDX_W'(LAST_IDX));

    // R1
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_end_o && !sob_i && bit_idx_o != IDX_W'(LAST_IDX))
        |=> bit_idx_o == IDX_W'($past(bit_idx_o) + IDX_W'(1)));

    // R1
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_end_o && !sob_i) |=> $stable(bit_idx_o));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sob_i |=> bit_idx_o == '0);
endmodule

bind lin_bit_timer lin_bt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sob_i     (sob_i),
    .bit_end_o (bit_end_o),
    .bit_idx_o (bit_idx_o)
);

// File: tb/test_lin_bit_timer.sv
module test_lin_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sob = 1'b0;
    logic       master = 1'b0;
    logic [1:0] field = 2'd0;
    logic [7:0] pre = 8'd0;
    logic [3:0] frac = 4'd0;
    logic [2:0] sel = 3'd0;
    logic       bit_end;
    logic [3:0] idx;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lin_bit_timer i_lin_bit_timer (
        .clk(clk), .rst_n(rst_n), .sob_i(sob), .master_i(master),
        .field_i(field), .pre_i(pre), .frac_i(frac), .sel_i(sel),
        .bit_end_o(bit_end), .bit_idx_o(idx)
    );

    function automatic int exp_extra(int s, int pos);
        bit ev = (pos % 2 == 0) && (pos <= 8);
        case (s)
            1: return int'(pos == 0 || pos == 8);
            2: return int'(pos == 0 || pos == 4 || pos == 8);
            3: return int'(pos == 0 || pos == 2 || pos == 4 || pos == 8);
            4: return int'(ev);
            5: return int'(ev || pos == 1 || pos == 9);
            6: return int'(ev || pos == 1 || pos == 5 || pos == 9);
            7: return int'(pos != 7);
            default: return 0;
        endcase
    endfunction

    function automatic int exp_mod(int ms, int fld);
        return int'(fld == 1 || fld == 2 || (ms == 1 && fld == 0));
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive a start pulse at the current negedge; returns in cycle 1 of position 0
    task automatic start_byte(int p, int m, int s, int ms, int fld);
        pre = 8'(p); frac = 4'(m); sel = 3'(s); master = 1'(ms); field = 2'(fld);
        sob = 1'b1;
        @(negedge clk);
        sob = 1'b0;
    endtask

    // time all ten positions; returns at the negedge where the stop strobe is seen
    task automatic measure_slot(int p, int m, int s, int ms, int fld, bit mid_change);
        int md = exp_mod(ms, fld);
        for (int pos = 0; pos < 10; pos++) begin
            int len = 1;
            int d = md * exp_extra(s, pos);
            int e = (p == 0) ? 32 : 16 * (p + 1) + m + d;
            string tag;
            while (!bit_end && len < 5000) begin
                @(negedge clk);
                len++;
            end
            if (mid_change && pos >= 4) tag = "R7";
            else if (p == 0)            tag = "R3";
            else if (d == 1)            tag = "R4";
            else if (md == 0)           tag = "R5";
            else                        tag = "R2";
            chk(tag, len, e);
            chk("R1", int'(idx), pos);
            if (mid_change && pos == 3) begin
                pre = 8'd0; frac = 4'd0; sel = 3'(s + 3);
                field = 2'd3; master = ~master;
            end
            if (pos < 9) begin
                @(negedge clk);
                chk("R6", int'(bit_end), 0);
            end
        end
    endtask

    task automatic idle_check();
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (k % 10 == 9) begin
                chk("R1", int'(bit_end), 0);
                chk("R1", int'(idx), 9);
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", int'(bit_end), 0);
        chk("R10", int'(idx), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10", int'(bit_end), 0);
        chk("R10", int'(idx), 0);

        // sweep S, role and field with small prescalers
        for (int s = 0; s < 8; s++) begin
            for (int ms = 0; ms < 2; ms++) begin
                for (int fld = 0; fld < 4; fld++) begin
                    int p = 1 + (s % 3);
                    int m = (s * 5 + fld * 3 + ms) % 16;
                    start_byte(p, m, s, ms, fld);
                    measure_slot(p, m, s, ms, fld, 1'b0);
                    idle_check();
                end
            end
        end

        // R3: P = 0 ignores M and S in both roles
        start_byte(0, 15, 7, 1, 0);
        measure_slot(0, 15, 7, 1, 0, 1'b0);
        idle_check();
        start_byte(0, 9, 5, 0, 2);
        measure_slot(0, 9, 5, 0, 2, 1'b0);
        idle_check();

        // R7: settings scrambled after position 3
        start_byte(2, 7, 6, 1, 0);
        measure_slot(2, 7, 6, 1, 0, 1'b1);
        idle_check();

        // R9: next start pulse in the stop-bit strobe cycle
        start_byte(1, 3, 7, 0, 1);
        measure_slot(1, 3, 7, 0, 1, 1'b0);
        chk("R9", int'(bit_end), 1);
        start_byte(2, 11, 5, 1, 2);
        chk("R9", int'(idx), 0);
        measure_slot(2, 11, 5, 1, 2, 1'b0);
        idle_check();

        // R8: restart in the middle of position 2
        start_byte(1, 0, 4, 1, 1);
        repeat (80) @(negedge clk);
        start_byte(3, 14, 3, 0, 2);
        chk("R8", int'(idx), 0);
        measure_slot(3, 14, 3, 0, 2, 1'b0);
        idle_check();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule